// File: doc/BRIEF.md
# Video Output Pixel Formatter

This block is the last formatting stage in front of one display output. Two upstream video paths, main and auxiliary, each deliver a 3-component pixel in two forms: the unconverted pixel and the one that went through a colour matrix. The formatter picks one of those four, or a programmable forced colour. It then routes any input component to any output channel, limits the component values with one of several clip modes, and rounds each component to 8, 10 or 12 significant bits.

Components are `CW` bits wide (12 by default). In every pixel bus, component 0 (bits CW-1:0) is Y/G, component 1 is Cb/B and component 2 is Cr/R. The output bus uses the same order for the G/Y, B/Cb and R/Cr channels.

Software writes a small register set through a single write port. The writes go into staging copies. These are copied to the working settings only on a frame-start strobe. The pixel that comes with the strobe is the first one formatted with the new settings. The pixel path has two register stages, and data-valid and the two sync lines travel alongside it.

Top module: `pix_fmt_top`

## Requirements
- R1: Source select is configuration bits 3:0. Code 15 outputs the forced colour. Any other code takes the auxiliary path when bit 3 is 1 and the main path when bit 3 is 0 (0/1 main, 8/9 aux).
- R2: For a path source, select bit 0 = 0 passes the unconverted pixel and bit 0 = 1 passes the matrix-converted pixel.
- R3: Each output channel has a 2-bit selector: bits 25:24 for R/Cr, 21:20 for G/Y, 17:16 for B/Cb. Code 1 picks input Cb/B, code 2 picks Cr/R, and codes 0 and 3 pick Y/G.
- R4: The clip mode is bits 10:8. Codes 0 and 5–7 leave values unclipped. Code 2 clamps every channel to 16..235 scaled by 2^(CW-8). Code 3 clamps G/Y to that range and B/Cb and R/Cr to 16..240 scaled.
- R5: Clip code 1 clamps each channel to 1..2^N−2 in units of the target precision N, so after rounding no component is all zeros or all ones.
- R6: Clip code 4 clamps each channel to the limits programmed for its own component: lower limit in bits CW-1:0 and upper limit in bits CW+15:16 of that component's limit register.
- R7: The rounding mode is bits 5:4. Code 0 gives 8 bits, 1 gives 10 bits, 2 and 3 give CW bits. Rounding adds half an LSB of the target precision and then zeroes the dropped low bits. Clipping is applied before rounding.
- R8: A rounding sum that exceeds the largest CW-bit value saturates, so the result is the largest code at the target precision.
- R9: Register writes change the output only from the pixel that comes with a frame-start strobe. Pixels sent without a strobe keep the previous settings.
- R10: A pixel presented with valid appears at the output two clock cycles later. hsync and vsync are delayed by the same two cycles.
- R11: Reset clears all registers to zero. The outputs are zero, and with the all-zero configuration every channel shows the main unconverted Y/G component rounded to 8 bits.
- R12: Write addresses: 0 is the configuration word. 1, 2 and 3 are the forced Y/G, Cb/B and Cr/R values in bits CW-1:0. 4, 5 and 6 are the clip limits for Y/G, Cb/B and Cr/R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | DW | Register write data |
| frame_start_i | input | 1 | Applies staged settings from this cycle on |
| valid_i | input | 1 | Input pixel valid |
| hsync_i | input | 1 | Horizontal sync in |
| vsync_i | input | 1 | Vertical sync in |
| main_raw_i | input | 3*CW | Main path, unconverted pixel |
| main_csc_i | input | 3*CW | Main path, matrix-converted pixel |
| aux_raw_i | input | 3*CW | Auxiliary path, unconverted pixel |
| aux_csc_i | input | 3*CW | Auxiliary path, matrix-converted pixel |
| valid_o | output | 1 | Output pixel valid |
| hsync_o | output | 1 | Horizontal sync out |
| vsync_o | output | 1 | Vertical sync out |
| pix_o | output | 3*CW | Formatted pixel (G/Y, B/Cb, R/Cr from LSB up) |

## Verification
The four source buses carry distinct values in every component, so any wrong pick of path, conversion form or component shows up as a mismatch. Permutations cover identity, a rotation, all channels from one component, and the code-3 fallback. This separates selector positions from selector codes. Clip tests use components at 0, full scale and mid scale, which hit both bounds of every clip mode. Rounding tests use values just below and above half an LSB, and full scale to force saturation. A configuration written without a strobe, followed by the same write with a strobe, tells deferred application apart from immediate application.

// File: rtl/pix_fmt_pkg.sv
package pix_fmt_pkg;
  localparam int unsigned NCH = 3;
  localparam int unsigned CH_YG = 0;
  localparam int unsigned CH_CB = 1;
  localparam int unsigned CH_CR = 2;

  localparam logic [2:0] CLIP_OFF   = 3'd0;
  localparam logic [2:0] CLIP_EAV   = 3'd1;
  localparam logic [2:0] CLIP_LIM_Y = 3'd2;
  localparam logic [2:0] CLIP_LIM_C = 3'd3;
  localparam logic [2:0] CLIP_PROG  = 3'd4;

  localparam logic [1:0] RND_8  = 2'd0;
  localparam logic [1:0] RND_10 = 2'd1;
  localparam logic [1:0] RND_12 = 2'd2;

  localparam logic [3:0] SRC_FORCE = 4'hf;
  localparam int unsigned RND_LSB  = 4;
  localparam int unsigned CLIP_LSB = 8;

  localparam int unsigned ADDR_CFG   = 0;
  localparam int unsigned ADDR_FORCE = 1;
  localparam int unsigned ADDR_LIM   = 4;
  localparam int unsigned LIM_HI_LSB = 16;

  // selector position per output channel; decoded by the selection stage
  function automatic int unsigned perm_lsb(int unsigned ch);
    case (ch)
      CH_YG:   return 20;
      CH_CB:   return 16;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/pix_fmt_regs.sv
module pix_fmt_regs
  import pix_fmt_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [DW-1:0]            wr_data_i,
  input  logic                     frame_start_i,
  output logic [DW-1:0]            cfg_o,
  output logic [NCH-1:0][CW-1:0]   force_o,
  output logic [NCH-1:0][CW-1:0]   lo_o,
  output logic [NCH-1:0][CW-1:0]   hi_o
);
  logic [DW-1:0]          stg_cfg_q, act_cfg_q;
  logic [NCH-1:0][CW-1:0] stg_force_q, act_force_q;
  logic [NCH-1:0][CW-1:0] stg_lo_q, act_lo_q;
  logic [NCH-1:0][CW-1:0] stg_hi_q, act_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_cfg_q   <= '0;
      stg_force_q <= '0;
      stg_lo_q    <= '0;
      stg_hi_q    <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == AW'(ADDR_CFG)) stg_cfg_q <= wr_data_i;
      for (int c = 0; c < NCH; c++) begin
        if (wr_addr_i == AW'(ADDR_FORCE + c)) stg_force_q[c] <= wr_data_i[CW-1:0];
        if (wr_addr_i == AW'(ADDR_LIM + c)) begin
          stg_lo_q[c] <= wr_data_i[CW-1:0];
          stg_hi_q[c] <= wr_data_i[LIM_HI_LSB +: CW];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_cfg_q   <= '0;
      act_force_q <= '0;
      act_lo_q    <= '0;
      act_hi_q    <= '0;
    end else if (frame_start_i) begin
      act_cfg_q   <= stg_cfg_q;
      act_force_q <= stg_force_q;
      act_lo_q    <= stg_lo_q;
      act_hi_q    <= stg_hi_q;
    end
  end

  // strobe cycle already formats with the staged set
  assign cfg_o   = frame_start_i ? stg_cfg_q   : act_cfg_q;
  assign force_o = frame_start_i ? stg_force_q : act_force_q;
  assign lo_o    = frame_start_i ? stg_lo_q    : act_lo_q;
  assign hi_o    = frame_start_i ? stg_hi_q    : act_hi_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(act_cfg_q) && $stable(act_lo_q) && $stable(act_hi_q)); // R9
  AST_FORCE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(act_force_q)); // R9
endmodule

// File: rtl/pix_fmt_sel.sv
module pix_fmt_sel
  import pix_fmt_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned DW = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [DW-1:0]          cfg_i,
  input  logic [NCH-1:0][CW-1:0] force_i,
  input  logic [NCH-1:0][CW-1:0] lo_i,
  input  logic [NCH-1:0][CW-1:0] hi_i,
  input  logic [NCH-1:0][CW-1:0] main_raw_i,
  input  logic [NCH-1:0][CW-1:0] main_csc_i,
  input  logic [NCH-1:0][CW-1:0] aux_raw_i,
  input  logic [NCH-1:0][CW-1:0] aux_csc_i,
  input  logic                   valid_i,
  input  logic                   hsync_i,
  input  logic                   vsync_i,
  output logic [NCH-1:0][CW-1:0] pix_o,
  output logic [2:0]             clip_o,
  output logic [1:0]             rnd_o,
  output logic [NCH-1:0][CW-1:0] lo_o,
  output logic [NCH-1:0][CW-1:0] hi_o,
  output logic                   valid_o,
  output logic                   hsync_o,
  output logic                   vsync_o
);
  logic [3:0]             src_sel;
  logic [NCH-1:0][CW-1:0] src, perm;
  logic                   unused_cfg;

  assign src_sel    = cfg_i[3:0];
  assign unused_cfg = ^{cfg_i[DW-1:26], cfg_i[23:22], cfg_i[19:18], cfg_i[15:11], cfg_i[7:6]};

  // bit0 = 1 takes the converted pixel (inverted bypass sense)
  always_comb begin
    if (src_sel == SRC_FORCE)  src = force_i;
    else if (src_sel[3])       src = src_sel[0] ? aux_csc_i  : aux_raw_i;
    else                       src = src_sel[0] ? main_csc_i : main_raw_i;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_perm
    localparam int unsigned L = perm_lsb(ch);
    logic [1:0] code;
    assign code     = cfg_i[L +: 2];
    assign perm[ch] = (code == 2'd1) ? src[CH_CB] :
                      (code == 2'd2) ? src[CH_CR] : src[CH_YG];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o   <= '0;
      clip_o  <= CLIP_OFF;
      rnd_o   <= RND_8;
      lo_o    <= '0;
      hi_o    <= '0;
      valid_o <= 1'b0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
    end else begin
      pix_o   <= perm;
      clip_o  <= cfg_i[CLIP_LSB +: 3];
      rnd_o   <= cfg_i[RND_LSB +: 2];
      lo_o    <= lo_i;
      hi_o    <= hi_i;
      valid_o <= valid_i;
      hsync_o <= hsync_i;
      vsync_o <= vsync_i;
    end
  end

  AST_S1_VALID_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R10
  AST_S1_VALID_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R10
endmodule

// File: rtl/pix_fmt_shape.sv
module pix_fmt_shape
  import pix_fmt_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NCH-1:0][CW-1:0] pix_i,
  input  logic [2:0]             clip_i,
  input  logic [1:0]             rnd_i,
  input  logic [NCH-1:0][CW-1:0] lo_i,
  input  logic [NCH-1:0][CW-1:0] hi_i,
  input  logic                   valid_i,
  input  logic                   hsync_i,
  input  logic                   vsync_i,
  output logic [NCH-1:0][CW-1:0] pix_o,
  output logic                   valid_o,
  output logic                   hsync_o,
  output logic                   vsync_o
);
  localparam logic [CW:0]   ONE    = (CW+1)'(1);
  localparam logic [CW-1:0] LIM_LO = CW'(16  << (CW-8));
  localparam logic [CW-1:0] Y_HI   = CW'(235 << (CW-8));
  localparam logic [CW-1:0] C_HI   = CW'(240 << (CW-8));

  int unsigned            drop;
  logic [CW-1:0]          eav_lo, eav_hi;
  logic [NCH-1:0][CW-1:0] lo_c, hi_c, clp, res;

  function automatic logic [CW-1:0] rnd_fn(logic [CW-1:0] v, int unsigned s);
    logic [CW:0]   sum;
    logic [CW-1:0] msk;
    if (s == 0) return v;
    sum = {1'b0, v} + (ONE << (s - 1));
    if (sum[CW]) sum = {1'b0, {CW{1'b1}}};
    msk = ~((CW'(1) << s) - CW'(1));
    return sum[CW-1:0] & msk;
  endfunction

  always_comb begin
    case (rnd_i)
      RND_8:   drop = CW - 8;
      RND_10:  drop = CW - 10;
      default: drop = 0;
    endcase
    eav_lo = CW'(ONE << drop);
    eav_hi = CW'((ONE << CW) - (ONE << (drop + 1)));
    for (int ch = 0; ch < NCH; ch++) begin
      case (clip_i)
        CLIP_EAV:   begin lo_c[ch] = eav_lo; hi_c[ch] = eav_hi; end
        CLIP_LIM_Y: begin lo_c[ch] = LIM_LO; hi_c[ch] = Y_HI;   end
        CLIP_LIM_C: begin
          lo_c[ch] = LIM_LO;
          hi_c[ch] = (ch == CH_YG) ? Y_HI : C_HI;
        end
        CLIP_PROG:  begin lo_c[ch] = lo_i[ch]; hi_c[ch] = hi_i[ch]; end
        default:    begin lo_c[ch] = '0; hi_c[ch] = '1; end
      endcase
      if (pix_i[ch] < lo_c[ch])      clp[ch] = lo_c[ch];
      else if (pix_i[ch] > hi_c[ch]) clp[ch] = hi_c[ch];
      else                           clp[ch] = pix_i[ch];
      res[ch] = rnd_fn(clp[ch], drop);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o   <= '0;
      valid_o <= 1'b0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
    end else begin
      pix_o   <= res;
      valid_o <= valid_i;
      hsync_o <= hsync_i;
      vsync_o <= vsync_i;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    AST_EAV_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clip_i == CLIP_EAV && rnd_i == RND_8) |=>
      (pix_o[ch][CW-1:CW-8] != 8'h00 && pix_o[ch][CW-1:CW-8] != 8'hff)); // R5
    AST_RND8_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rnd_i == RND_8) |=> (pix_o[ch][CW-9:0] == '0)); // R7
  end

  AST_S2_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R10
endmodule

// File: rtl/pix_fmt_top.sv
module pix_fmt_top
  import pix_fmt_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              frame_start_i,
  input  logic              valid_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [3*CW-1:0]   main_raw_i,
  input  logic [3*CW-1:0]   main_csc_i,
  input  logic [3*CW-1:0]   aux_raw_i,
  input  logic [3*CW-1:0]   aux_csc_i,
  output logic              valid_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic [3*CW-1:0]   pix_o
);
  logic [DW-1:0]          cfg;
  logic [NCH-1:0][CW-1:0] force_c, lo_c, hi_c;
  logic [NCH-1:0][CW-1:0] mr, mc, ar, ac;
  logic [NCH-1:0][CW-1:0] s1_pix, s1_lo, s1_hi, s2_pix;
  logic [2:0]             s1_clip;
  logic [1:0]             s1_rnd;
  logic                   s1_valid, s1_hs, s1_vs;

  assign mr    = main_raw_i;
  assign mc    = main_csc_i;
  assign ar    = aux_raw_i;
  assign ac    = aux_csc_i;
  assign pix_o = s2_pix;

  pix_fmt_regs #(.CW(CW), .AW(AW), .DW(DW)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .frame_start_i,
    .cfg_o(cfg), .force_o(force_c), .lo_o(lo_c), .hi_o(hi_c)
  );

  pix_fmt_sel #(.CW(CW), .DW(DW)) i_sel (
    .clk_i, .rst_ni, .cfg_i(cfg), .force_i(force_c), .lo_i(lo_c), .hi_i(hi_c),
    .main_raw_i(mr), .main_csc_i(mc), .aux_raw_i(ar), .aux_csc_i(ac),
    .valid_i, .hsync_i, .vsync_i,
    .pix_o(s1_pix), .clip_o(s1_clip), .rnd_o(s1_rnd), .lo_o(s1_lo), .hi_o(s1_hi),
    .valid_o(s1_valid), .hsync_o(s1_hs), .vsync_o(s1_vs)
  );

  pix_fmt_shape #(.CW(CW)) i_shape (
    .clk_i, .rst_ni, .pix_i(s1_pix), .clip_i(s1_clip), .rnd_i(s1_rnd),
    .lo_i(s1_lo), .hi_i(s1_hi), .valid_i(s1_valid), .hsync_i(s1_hs), .vsync_i(s1_vs),
    .pix_o(s2_pix), .valid_o, .hsync_o, .vsync_o
  );

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o); // R10
  AST_HSYNC_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_i |=> ##1 hsync_o); // R10
  AST_VSYNC_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> ##1 !vsync_o); // R10
endmodule

// File: tb/test_pix_fmt_top.sv
module test_pix_fmt_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, fs = 1'b0, vin = 1'b0, hs = 1'b0, vs = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [35:0] mr = '0, mc = '0, ar = '0, ac = '0;
  logic vout, hso, vso;
  logic [35:0] pout;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_fmt_top #(.CW(CW), .AW(3), .DW(32)) i_pix_fmt_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .frame_start_i(fs), .valid_i(vin), .hsync_i(hs), .vsync_i(vs),
    .main_raw_i(mr), .main_csc_i(mc), .aux_raw_i(ar), .aux_csc_i(ac),
    .valid_o(vout), .hsync_o(hso), .vsync_o(vso), .pix_o(pout)
  );

  int checks = 0, errors = 0;
  logic [31:0] s_cfg = '0, a_cfg = '0;
  int s_force[3], a_force[3], s_lo[3], a_lo[3], s_hi[3], a_hi[3];
  logic [37:0] exp_q[$];
  string tag_q[$];

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] pk(int y, int b, int r);
    return {r[11:0], b[11:0], y[11:0]};
  endfunction

  function automatic logic [31:0] cfgw(int sel, int rs, int gs, int bs, int clip, int rnd);
    return {6'b0, rs[1:0], 2'b0, gs[1:0], 2'b0, bs[1:0], 5'b0, clip[2:0], 2'b0, rnd[1:0], sel[3:0]};
  endfunction

  function automatic logic [35:0] model(logic [35:0] m_r, logic [35:0] m_c, logic [35:0] a_r, logic [35:0] a_c);
    logic [35:0] src, res;
    int pos, code, comp, v, lo, hi, rm, n, sh, mode;
    if (a_cfg[3:0] == 4'hf)
      for (int c = 0; c < 3; c++) src[c*12 +: 12] = a_force[c][11:0];
    else if (a_cfg[3]) src = a_cfg[0] ? a_c : a_r;
    else               src = a_cfg[0] ? m_c : m_r;
    rm = int'(a_cfg[5:4]);
    n = (rm == 0) ? 8 : (rm == 1) ? 10 : 12;
    sh = 12 - n;
    mode = int'(a_cfg[10:8]);
    for (int ch = 0; ch < 3; ch++) begin
      pos = (ch == 0) ? 20 : (ch == 1) ? 16 : 24;
      code = int'(a_cfg[pos +: 2]);
      comp = (code == 1) ? 1 : (code == 2) ? 2 : 0;
      v = int'(src[comp*12 +: 12]);
      case (mode)
        1: begin lo = 1 << sh; hi = ((1 << n) - 2) << sh; end
        2: begin lo = 256; hi = 3760; end
        3: begin lo = 256; hi = (ch == 0) ? 3760 : 3840; end
        4: begin lo = a_lo[ch]; hi = a_hi[ch]; end
        default: begin lo = 0; hi = 4095; end
      endcase
      if (v < lo) v = lo;
      else if (v > hi) v = hi;
      if (sh > 0) begin
        v = v + (1 << (sh - 1));
        if (v > 4095) v = 4095;
        v = (v >> sh) << sh;
      end
      res[ch*12 +: 12] = v[11:0];
    end
    return res;
  endfunction

  task automatic wr(int addr, logic [31:0] data);
    wr_en = 1'b1; wr_addr = addr[2:0]; wr_data = data;
    if (addr == 0) s_cfg = data;
    else if (addr <= 3) s_force[addr-1] = int'(data[11:0]);
    else if (addr <= 6) begin s_lo[addr-4] = int'(data[11:0]); s_hi[addr-4] = int'(data[27:16]); end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic px(logic [35:0] m_r, logic [35:0] m_c, logic [35:0] a_r, logic [35:0] a_c,
                    bit start, bit h, bit v, string req);
    mr = m_r; mc = m_c; ar = a_r; ac = a_c;
    vin = 1'b1; hs = h; vs = v; fs = start;
    if (start) begin
      a_cfg = s_cfg;
      for (int c = 0; c < 3; c++) begin
        a_force[c] = s_force[c]; a_lo[c] = s_lo[c]; a_hi[c] = s_hi[c];
      end
    end
    exp_q.push_back({h, v, model(m_r, m_c, a_r, a_c)});
    tag_q.push_back(req);
    @(negedge clk);
    vin = 1'b0; fs = 1'b0; hs = 1'b0; vs = 1'b0;
  endtask

  // distinct source patterns
  logic [35:0] P_MR, P_MC, P_AR, P_AC;
  initial begin
    P_MR = pk(12'h123, 12'h456, 12'h789);
    P_MC = pk(12'h2a1, 12'h5b2, 12'h8c3);
    P_AR = pk(12'h314, 12'h625, 12'h936);
    P_AC = pk(12'h4d7, 12'h7e8, 12'hAf9);
  end

  // monitor: scoreboard pop and compare
  logic [37:0] got_e;
  string got_t;
  always @(negedge clk) begin
    if (rst_n && vout) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected output", {26'b0, hso, vso, pout}, 64'h0);
      else begin
        got_e = exp_q.pop_front();
        got_t = tag_q.pop_front();
        check({hso, vso, pout} == got_e, got_t, {26'b0, hso, vso, pout}, {26'b0, got_e});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pout == '0 && !vout && !hso && !vso, "R11 reset outputs", {27'b0, vout, pout}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 zero config, R10 latency
    px(P_MR, P_MC, P_AR, P_AC, 1'b0, 1'b0, 1'b0, "R11 zero config");
    check(vout == 1'b0, "R10 not yet", {63'b0, vout}, 64'h0);
    @(negedge clk);
    check(vout == 1'b1, "R10 two cycles", {63'b0, vout}, 64'h1);

    // R2 / R3 identity permutation at full precision
    wr(0, cfgw(1, 2, 0, 1, 0, 2));
    px(P_MR, P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R2 main converted");
    wr(0, cfgw(0, 2, 0, 1, 0, 2));
    px(P_MR, P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R2 main bypass");
    // R1 sources
    wr(0, cfgw(8, 2, 0, 1, 0, 2));
    px(P_MR, P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R1 aux raw");
    wr(0, cfgw(9, 2, 0, 1, 0, 2));
    px(P_MR, P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R1 aux converted");
    wr(0, cfgw(14, 2, 0, 1, 0, 2));
    px(P_MR, P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R1 code14 aux raw");
    wr(1, 32'h0000_0abc); wr(2, 32'h0000_0def); wr(3, 32'h0000_0135);
    wr(0, cfgw(15, 2, 0, 1, 0, 2));
    px(P_MR, P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R1 R12 forced colour");
    // R3 permutations
    wr(0, cfgw(0, 0, 1, 2, 0, 2));
    px(P_MR, P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R3 rotated");
    wr(0, cfgw(0, 2, 2, 2, 0, 2));
    px(P_MR, P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R3 all Cr");
    wr(0, cfgw(0, 3, 3, 1, 0, 2));
    px(P_MR, P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R3 code3");
    // R4 limited range and undefined clip codes
    wr(0, cfgw(0, 2, 0, 1, 2, 2));
    px(pk(12'h010, 12'hfff, 12'h800), P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R4 limited Y");
    px(pk(12'hfff, 12'h000, 12'hff0), P_MC, P_AR, P_AC, 1'b0, 1'b0, 1'b0, "R4 limited Y hi");
    wr(0, cfgw(0, 2, 0, 1, 3, 2));
    px(pk(12'hfff, 12'hfff, 12'h005), P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R4 limited C");
    wr(0, cfgw(0, 2, 0, 1, 6, 2));
    px(pk(12'hfff, 12'h000, 12'h001), P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R4 code6 no clip");
    // R5 timing-code-safe clamp
    wr(0, cfgw(0, 2, 0, 1, 1, 0));
    px(pk(12'h000, 12'hfff, 12'h7f0), P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R5 eav 8bit");
    wr(0, cfgw(0, 2, 0, 1, 1, 1));
    px(pk(12'hfff, 12'h000, 12'h002), P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R5 eav 10bit");
    // R6 programmed limits
    wr(4, {4'h0, 12'h600, 4'h0, 12'h200});
    wr(5, {4'h0, 12'h900, 4'h0, 12'h100});
    wr(6, {4'h0, 12'h400, 4'h0, 12'h300});
    wr(0, cfgw(0, 2, 0, 1, 4, 2));
    px(pk(12'h050, 12'hfff, 12'h350), P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R6 prog limits");
    px(pk(12'hfff, 12'h000, 12'h000), P_MC, P_AR, P_AC, 1'b0, 1'b0, 1'b0, "R6 prog limits other side");
    // R7 rounding
    wr(0, cfgw(0, 2, 0, 1, 0, 1));
    px(pk(12'h003, 12'h001, 12'h7fe), P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R7 round 10bit");
    wr(0, cfgw(0, 2, 0, 1, 0, 0));
    px(pk(12'h017, 12'h018, 12'h007), P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R7 round 8bit");
    wr(0, cfgw(0, 2, 0, 1, 0, 3));
    px(pk(12'h017, 12'h001, 12'hfff), P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R7 code3 full width");
    // R8 saturation
    wr(0, cfgw(0, 2, 0, 1, 0, 0));
    px(pk(12'hfff, 12'hff9, 12'hff7), P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R8 saturate 8bit");
    wr(0, cfgw(0, 2, 0, 1, 0, 1));
    px(pk(12'hfff, 12'hffe, 12'hffd), P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R8 saturate 10bit");
    // R9 deferred application
    wr(0, cfgw(9, 0, 1, 2, 2, 0));
    px(P_MR, P_MC, P_AR, P_AC, 1'b0, 1'b0, 1'b0, "R9 no strobe keeps old");
    px(P_MR, P_MC, P_AR, P_AC, 1'b0, 1'b0, 1'b0, "R9 no strobe keeps old 2");
    px(P_MR, P_MC, P_AR, P_AC, 1'b1, 1'b0, 1'b0, "R9 strobe applies");
    // R10 sync alignment
    px(P_MR, P_MC, P_AR, P_AC, 1'b0, 1'b1, 1'b0, "R10 hsync");
    px(P_MR, P_MC, P_AR, P_AC, 1'b0, 1'b0, 1'b1, "R10 vsync");
    px(P_MR, P_MC, P_AR, P_AC, 1'b0, 1'b1, 1'b1, "R10 both syncs");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R10 all pixels emitted", 64'(exp_q.size()), 64'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule